// File: doc/BRIEF.md
# Dual-Clock Mailbox Bypass Pair

This block carries single control words between two ports that run on unrelated clocks, with no queue in between. Port A posts words into an outbound mailbox that port B collects. Port B posts words into a return mailbox that port A collects. Each mailbox holds one word and has a flag. The flag goes low when a word is posted. It goes back high only after the far side has collected that word. While the flag is low, the writer cannot post another word.

On each port, a mailbox-select input steers the port's read bus. When it is high, the bus shows that port's incoming mailbox. When it is low, the bus shows the word that the external queue presents. The usable width of both mailboxes follows the bus size configured for port B. Unused upper input lines are discarded, and unused upper output lines read as zero.

Each flag is built from two toggle bits, one owned by each clock domain. Each toggle bit is carried into the other domain through a chain of synchronising flops.

Top module: `mbox_bypass`

## Requirements
- R1: After reset both mailbox flags (`a_mbf1`, `b_mbf2`) are high, both ready outputs (`b_mail1_rdy`, `a_mail2_rdy`) are low, and both mailboxes read as zero.
- R2: A port A access with `a_cs`, `a_en`, `a_wr` and `a_mbox` all high at a `clk_a` rising edge while `a_mbf1` is high stores the masked `a_din` into the outbound mailbox. It drives `a_mbf1` low from that edge on. `b_mail1_rdy` rises within three `clk_b` edges.
- R3: While `a_mbf1` is low, port A mailbox writes are ignored and the stored word is unchanged. While `b_mbf2` is low, port B mailbox writes are ignored in the same way.
- R4: A port B read of the outbound mailbox (`b_cs`, `b_en`, `b_mbox` high and `b_wr` low at a `clk_b` edge) while `b_mail1_rdy` is high drops `b_mail1_rdy` after that edge. `a_mbf1` returns high within three `clk_a` edges.
- R5: A mailbox keeps its word after a read and changes only on a new accepted write.
- R6: The return mailbox mirrors R2 and R4. A port B write (`b_cs`, `b_en`, `b_wr`, `b_mbox` high) drives `b_mbf2` low and raises `a_mail2_rdy`. A port A read (`a_cs`, `a_en`, `a_mbox` high, `a_wr` low) clears `a_mail2_rdy` and later returns `b_mbf2` high.
- R7: `b_size` selects the usable mailbox width:
  - `2'b00` or `2'b11`: all 36 bits.
  - `2'b01`: bits 17:0.
  - `2'b10`: bits 8:0.
  
  Input bits above the usable width are dropped on write, and the matching output bits read zero.
- R8: A port's read bus shows data only while its chip select is high and its write input is low. In that state it shows the incoming mailbox if mailbox-select is high, and the external queue word (`a_fifo_q` / `b_fifo_q`) if it is low. At all other times the bus is zero.
- R9: An access with mailbox-select low, or with enable low, neither writes a mailbox nor changes any flag.
- R10: A mailbox read while no word is pending has no effect. The flags and ready outputs stay as they were, and the next write is still accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| clk_b | input | 1 | Port B clock, unrelated to clk_a |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| b_size | input | 2 | Port B bus size: 00/11 = 36, 01 = 18, 10 = 9 bits |
| a_cs | input | 1 | Port A chip select |
| a_en | input | 1 | Port A transfer enable |
| a_wr | input | 1 | Port A direction, 1 = write, 0 = read |
| a_mbox | input | 1 | Port A mailbox select, 1 = mailbox, 0 = queue |
| a_din | input | 36 | Port A write data |
| a_fifo_q | input | 36 | Queue output word presented to port A |
| a_dout | output | 36 | Port A read bus |
| a_mbf1 | output | 1 | Outbound mailbox flag, 1 = free, 0 = holds a word (clk_a domain) |
| a_mail2_rdy | output | 1 | Return mailbox holds an uncollected word (clk_a domain) |
| b_cs | input | 1 | Port B chip select |
| b_en | input | 1 | Port B transfer enable |
| b_wr | input | 1 | Port B direction, 1 = write, 0 = read |
| b_mbox | input | 1 | Port B mailbox select |
| b_din | input | 36 | Port B write data |
| b_fifo_q | input | 36 | Queue output word presented to port B |
| b_dout | output | 36 | Port B read bus |
| b_mbf2 | output | 1 | Return mailbox flag, 1 = free, 0 = holds a word (clk_b domain) |
| b_mail1_rdy | output | 1 | Outbound mailbox holds an uncollected word (clk_b domain) |

## Verification
The bench builds the block with its defaults: a 36-bit data path and two synchroniser stages. With two stages, every flag round trip completes within a few cycles of either clock. That lets the bench walk each mailbox through write, lockout, collect and release in both directions, and check every handover against a fixed cycle bound. The 36-bit width divides cleanly into the 18-bit and 9-bit sizes, so all three masks are reached by switching `b_size` between transfers.

// File: rtl/mbox_pkg.sv
`timescale 1ns/1ps
package mbox_pkg;

    typedef enum logic [1:0] {
        BUS_FULL    = 2'b00,
        BUS_HALF    = 2'b01,
        BUS_QUARTER = 2'b10,
        BUS_ALT     = 2'b11
    } bus_size_e;

    // Number of low lines that carry mailbox data for a given port B size.
    function automatic int unsigned usable_bits(input bus_size_e sz, input int unsigned full_w);
        case (sz)
            BUS_HALF:    return full_w / 2;
            BUS_QUARTER: return full_w / 4;
            default:     return full_w;
        endcase
    endfunction

endpackage

// File: rtl/mbox_sync.sv
`timescale 1ns/1ps
module mbox_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] stg_d, stg_q;

    always_comb begin
        stg_d = {stg_q[STAGES-2:0], d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= stg_d;
    end

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/mbox_lane.sv
`timescale 1ns/1ps
module mbox_lane #(
    parameter int DATA_W = 36,
    parameter int STAGES = 2
) (
    input  logic              wclk,
    input  logic              rclk,
    input  logic              rst_n,
    input  logic              w_push,
    input  logic [DATA_W-1:0] w_data,
    input  logic [DATA_W-1:0] w_mask,
    output logic              w_free,
    input  logic              r_pop,
    output logic              r_pending,
    output logic [DATA_W-1:0] store_q
);
    typedef struct packed {
        logic              tog;
        logic [DATA_W-1:0] data;
    } wside_t;

    typedef struct packed {
        logic tog;
    } rside_t;

    wside_t w_d, w_q;
    rside_t r_d, r_q;
    logic   rtog_in_w;
    logic   wtog_in_r;

    mbox_sync #(.STAGES(STAGES)) u_r2w (
        .clk(wclk), .rst_n(rst_n), .d(r_q.tog), .q(rtog_in_w)
    );

    mbox_sync #(.STAGES(STAGES)) u_w2r (
        .clk(rclk), .rst_n(rst_n), .d(w_q.tog), .q(wtog_in_r)
    );

    // Writer side: the word is accepted only while the synchronised view shows free.
    always_comb begin
        w_free = (w_q.tog == rtog_in_w);
        w_d    = w_q;
        if (w_push && w_free) begin
            w_d.tog  = ~w_q.tog;
            w_d.data = w_data & w_mask;
        end
    end

    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) w_q <= '0;
        else        w_q <= w_d;
    end

    // Reader side: a collect toggles only when a word is pending.
    always_comb begin
        r_pending = (wtog_in_r != r_q.tog);
        r_d       = r_q;
        if (r_pop && r_pending) begin
            r_d.tog = ~r_q.tog;
        end
    end

    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign store_q = w_q.data;
endmodule

// File: rtl/mbox_bypass.sv
`timescale 1ns/1ps
module mbox_bypass #(
    parameter int DATA_W = 36,
    parameter int STAGES = 2
) (
    input  logic              clk_a,
    input  logic              clk_b,
    input  logic              rst_n,
    input  logic [1:0]        b_size,
    input  logic              a_cs,
    input  logic              a_en,
    input  logic              a_wr,
    input  logic              a_mbox,
    input  logic [DATA_W-1:0] a_din,
    input  logic [DATA_W-1:0] a_fifo_q,
    output logic [DATA_W-1:0] a_dout,
    output logic              a_mbf1,
    output logic              a_mail2_rdy,
    input  logic              b_cs,
    input  logic              b_en,
    input  logic              b_wr,
    input  logic              b_mbox,
    input  logic [DATA_W-1:0] b_din,
    input  logic [DATA_W-1:0] b_fifo_q,
    output logic [DATA_W-1:0] b_dout,
    output logic              b_mbf2,
    output logic              b_mail1_rdy
);
    import mbox_pkg::*;

    logic [DATA_W-1:0] lane_mask;
    logic [DATA_W-1:0] mail1_q, mail2_q;
    int unsigned       usable;
    logic a_mb_wr, a_mb_rd, b_mb_wr, b_mb_rd;
    logic a_rd_on, b_rd_on;

    always_comb begin
        usable = usable_bits(bus_size_e'(b_size), DATA_W);
        for (int i = 0; i < DATA_W; i++) begin
            lane_mask[i] = (i < int'(usable));
        end
    end

    assign a_mb_wr = a_cs && a_en && a_wr && a_mbox;
    assign a_mb_rd = a_cs && a_en && !a_wr && a_mbox;
    assign b_mb_wr = b_cs && b_en && b_wr && b_mbox;
    assign b_mb_rd = b_cs && b_en && !b_wr && b_mbox;

    mbox_lane #(.DATA_W(DATA_W), .STAGES(STAGES)) u_out (
        .wclk(clk_a), .rclk(clk_b), .rst_n(rst_n),
        .w_push(a_mb_wr), .w_data(a_din), .w_mask(lane_mask), .w_free(a_mbf1),
        .r_pop(b_mb_rd), .r_pending(b_mail1_rdy), .store_q(mail1_q)
    );

    mbox_lane #(.DATA_W(DATA_W), .STAGES(STAGES)) u_ret (
        .wclk(clk_b), .rclk(clk_a), .rst_n(rst_n),
        .w_push(b_mb_wr), .w_data(b_din), .w_mask(lane_mask), .w_free(b_mbf2),
        .r_pop(a_mb_rd), .r_pending(a_mail2_rdy), .store_q(mail2_q)
    );

    assign a_rd_on = a_cs && !a_wr;
    assign b_rd_on = b_cs && !b_wr;

    always_comb begin
        a_dout = '0;
        b_dout = '0;
        if (a_rd_on) a_dout = a_mbox ? (mail2_q & lane_mask) : a_fifo_q;
        if (b_rd_on) b_dout = b_mbox ? (mail1_q & lane_mask) : b_fifo_q;
    end
endmodule

// File: rtl/mbox_bypass_chk.sv
`timescale 1ns/1ps
module mbox_bypass_chk #(
    parameter int DATA_W = 36
) (
    input logic              clk_a,
    input logic              clk_b,
    input logic              rst_n,
    input logic [1:0]        b_size,
    input logic              a_cs,
    input logic              a_en,
    input logic              a_wr,
    input logic              a_mbox,
    input logic              a_mbf1,
    input logic              b_cs,
    input logic              b_en,
    input logic              b_wr,
    input logic              b_mbox,
    input logic              b_mbf2,
    input logic [DATA_W-1:0] mail1_q,
    input logic [DATA_W-1:0] mail2_q
);
    // R2
    a_post_lock_chk: assert property (@(posedge clk_a) disable iff (!rst_n)
        (a_cs && a_en && a_wr && a_mbox && a_mbf1) |=> !a_mbf1);

    // R6
    b_post_lock_chk: assert property (@(posedge clk_b) disable iff (!rst_n)
        (b_cs && b_en && b_wr && b_mbox && b_mbf2) |=> !b_mbf2);

    // R3
    a_held_word_chk: assert property (@(posedge clk_a) disable iff (!rst_n)
        !a_mbf1 |=> $stable(mail1_q));

    // R3
    b_held_word_chk: assert property (@(posedge clk_b) disable iff (!rst_n)
        !b_mbf2 |=> $stable(mail2_q));

    // R9
    a_fall_cause_chk: assert property (@(posedge clk_a) disable iff (!rst_n)
        $fell(a_mbf1) |-> $past(a_cs && a_en && a_wr && a_mbox));

    // R7
    a_narrow_store_chk: assert property (@(posedge clk_a) disable iff (!rst_n)
        (a_cs && a_en && a_wr && a_mbox && a_mbf1 && b_size == 2'b10)
        |=> (mail1_q[DATA_W-1:DATA_W/4] == '0));
endmodule

bind mbox_bypass mbox_bypass_chk #(.DATA_W(DATA_W)) u_chk (
    .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n), .b_size(b_size),
    .a_cs(a_cs), .a_en(a_en), .a_wr(a_wr), .a_mbox(a_mbox), .a_mbf1(a_mbf1),
    .b_cs(b_cs), .b_en(b_en), .b_wr(b_wr), .b_mbox(b_mbox), .b_mbf2(b_mbf2),
    .mail1_q(mail1_q), .mail2_q(mail2_q)
);

// File: tb/sim_mbox_bypass.sv
`timescale 1ns/1ps
module sim_mbox_bypass;
    localparam int W = 36;

    logic clk_a = 0, clk_b = 0, rst_n = 0;
    logic [1:0] b_size = 2'b00;
    logic a_cs = 0, a_en = 0, a_wr = 0, a_mbox = 0;
    logic b_cs = 0, b_en = 0, b_wr = 0, b_mbox = 0;
    logic [W-1:0] a_din = '0, b_din = '0, a_fifo_q = 36'h123456789, b_fifo_q = 36'hABCDE0123;
    logic [W-1:0] a_dout, b_dout;
    logic a_mbf1, a_mail2_rdy, b_mbf2, b_mail1_rdy;
    int checks = 0, errors = 0;
    bit done = 0;

    always #10 clk_a = ~clk_a;
    always #15 clk_b = ~clk_b;

    mbox_bypass u0 (.*);

    task automatic check(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic a_post(input logic [W-1:0] v, input logic mb, input logic en);
        @(negedge clk_a);
        a_cs = 1; a_en = en; a_wr = 1; a_mbox = mb; a_din = v;
        @(negedge clk_a);
        a_cs = 0; a_en = 0; a_wr = 0; a_mbox = 0;
    endtask

    task automatic b_post(input logic [W-1:0] v);
        @(negedge clk_b);
        b_cs = 1; b_en = 1; b_wr = 1; b_mbox = 1; b_din = v;
        @(negedge clk_b);
        b_cs = 0; b_en = 0; b_wr = 0; b_mbox = 0;
    endtask

    task automatic b_read(input logic mb, input logic pop, output logic [W-1:0] v);
        @(negedge clk_b);
        b_cs = 1; b_en = pop; b_wr = 0; b_mbox = mb;
        #1 v = b_dout;
        @(negedge clk_b);
        b_cs = 0; b_en = 0; b_mbox = 0;
    endtask

    task automatic a_read(input logic mb, input logic pop, output logic [W-1:0] v);
        @(negedge clk_a);
        a_cs = 1; a_en = pop; a_wr = 0; a_mbox = mb;
        #1 v = a_dout;
        @(negedge clk_a);
        a_cs = 0; a_en = 0; a_mbox = 0;
    endtask

    task automatic t_reset();
        logic [W-1:0] v;
        check(a_mbf1 == 1 && b_mbf2 == 1, "R1 flags", {34'd0, a_mbf1, b_mbf2}, 36'd3);
        check(b_mail1_rdy == 0 && a_mail2_rdy == 0, "R1 ready", {34'd0, b_mail1_rdy, a_mail2_rdy}, 36'd0);
        b_read(1, 0, v);
        check(v == '0, "R1 mail1 zero", v, '0);
        a_read(1, 0, v);
        check(v == '0, "R1 mail2 zero", v, '0);
    endtask

    task automatic t_outbound();
        logic [W-1:0] v;
        a_post(36'h987654321, 1, 1);
        check(a_mbf1 == 0, "R2 flag low", {35'd0, a_mbf1}, 36'd0);
        repeat (3) @(negedge clk_b);
        check(b_mail1_rdy == 1, "R2 ready", {35'd0, b_mail1_rdy}, 36'd1);
        a_post(36'h111111111, 1, 1);
        b_read(1, 0, v);
        check(v == 36'h987654321, "R3 lockout", v, 36'h987654321);
        b_read(1, 1, v);
        check(v == 36'h987654321, "R8 mailbox on bus", v, 36'h987654321);
        check(b_mail1_rdy == 0, "R4 ready drop", {35'd0, b_mail1_rdy}, 36'd0);
        repeat (3) @(negedge clk_a);
        check(a_mbf1 == 1, "R4 flag release", {35'd0, a_mbf1}, 36'd1);
        b_read(1, 0, v);
        check(v == 36'h987654321, "R5 kept after read", v, 36'h987654321);
    endtask

    task automatic t_empty_pop();
        logic [W-1:0] v;
        b_read(1, 1, v);
        repeat (4) @(negedge clk_a);
        check(a_mbf1 == 1 && b_mail1_rdy == 0, "R10 no effect", {34'd0, a_mbf1, b_mail1_rdy}, 36'd2);
        a_post(36'h0CAFE0001, 1, 1);
        check(a_mbf1 == 0, "R10 next write accepted", {35'd0, a_mbf1}, 36'd0);
        repeat (3) @(negedge clk_b);
        b_read(1, 1, v);
        check(v == 36'h0CAFE0001, "R10 word", v, 36'h0CAFE0001);
        repeat (4) @(negedge clk_a);
    endtask

    task automatic t_return();
        logic [W-1:0] v;
        b_post(36'hA5A55A5A5);
        check(b_mbf2 == 0, "R6 flag low", {35'd0, b_mbf2}, 36'd0);
        repeat (3) @(negedge clk_a);
        check(a_mail2_rdy == 1, "R6 ready", {35'd0, a_mail2_rdy}, 36'd1);
        b_post(36'h000000777);
        a_read(1, 1, v);
        check(v == 36'hA5A55A5A5, "R6 word / R3 lockout", v, 36'hA5A55A5A5);
        check(a_mail2_rdy == 0, "R6 ready drop", {35'd0, a_mail2_rdy}, 36'd0);
        repeat (3) @(negedge clk_b);
        check(b_mbf2 == 1, "R6 flag release", {35'd0, b_mbf2}, 36'd1);
    endtask

    task automatic t_sizes();
        logic [W-1:0] v;
        b_size = 2'b01;
        a_post(36'hFFFFFFFFF, 1, 1);
        repeat (3) @(negedge clk_b);
        b_read(1, 1, v);
        check(v == 36'h00003FFFF, "R7 18-bit", v, 36'h00003FFFF);
        repeat (4) @(negedge clk_a);
        b_size = 2'b10;
        b_post(36'hFFFFFFFFF);
        repeat (3) @(negedge clk_a);
        a_read(1, 1, v);
        check(v == 36'h0000001FF, "R7 9-bit", v, 36'h0000001FF);
        b_size = 2'b11;
        a_read(1, 0, v);
        check(v == 36'h0000001FF, "R7 upper bits dropped at write", v, 36'h0000001FF);
        repeat (4) @(negedge clk_b);
        b_size = 2'b00;
    endtask

    task automatic t_mux();
        logic [W-1:0] v;
        b_read(0, 1, v);
        check(v == b_fifo_q, "R8 queue on bus", v, b_fifo_q);
        a_read(0, 1, v);
        check(v == a_fifo_q, "R8 queue on port A", v, a_fifo_q);
        @(negedge clk_b);
        b_cs = 0; b_wr = 0; b_mbox = 1;
        #1 check(b_dout == '0, "R8 idle bus zero", b_dout, '0);
        b_mbox = 0;
        a_post(36'h222222222, 0, 1);
        check(a_mbf1 == 1, "R9 queue write ignored", {35'd0, a_mbf1}, 36'd1);
        a_post(36'h333333333, 1, 0);
        check(a_mbf1 == 1, "R9 disabled write ignored", {35'd0, a_mbf1}, 36'd1);
        repeat (3) @(negedge clk_b);
        check(b_mail1_rdy == 0, "R9 no pending", {35'd0, b_mail1_rdy}, 36'd0);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #105 rst_n = 1;
        repeat (2) @(negedge clk_a);
        t_reset();
        t_outbound();
        t_empty_pop();
        t_return();
        t_sizes();
        t_mux();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule